// File: doc/BRIEF.md
# Multi-Word Memory Cycle Sequencer

This block runs the memory cycles of a DRAM array shared by a CPU and an I/O requester. Each cycle lasts exactly four CPU beats. In one cycle the block moves 1, 2 or 4 sixteen-bit words. The CPU keeps only a single-word buffer in each direction, so the block presents one word address per beat. It walks through the words of an aligned group either upward or downward.

At each cycle boundary a small contention resolver picks one requester. I/O wins unless the CPU's hold bit is set; while hold is set, the I/O requester is locked out. The grant is kept for the whole four-beat cycle. The granted 20-bit word address is split three ways. The top bits pick a bank. The rest leave the block in two 8-bit phases on a shared chip-address bus: the row byte first, then the column byte, each with its own strobe.

A requester raises its request and holds it until the edge that starts its cycle. A request that is still present at the last beat of a cycle starts the next cycle at once, with no idle beat between them.

Top module: `mem_cycle_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `cpu_gnt`, `io_gnt`, `row_strobe`, `col_strobe`, `word_valid` and `store` are low, and `beat`, `bank` and `chip_addr` are zero.
- R2: Every granted cycle lasts exactly four beats. `beat` reads 0, 1, 2, 3 on consecutive clocks, and the grant stays on the same requester for all four beats.
- R3: The size code selects the number of words moved in a cycle: 0 moves one word, 1 moves two, and 2 or 3 moves four. `word_valid` is high in beats 0 up to count-1 and low in the remaining beats.
- R4: Multi-word groups are aligned: the base address is the request address with its low size-code bits cleared. With the reverse flag low, the word in beat b is base+b.
- R5: With the reverse flag high, the word in beat b is base+count-1-b, so the group is walked from its highest word down.
- R6: Address bits 19:16 of the aligned base drive `bank` for the whole cycle. In beat 0, `row_strobe` is high and `chip_addr` carries bits 15:8. In beat 1, `col_strobe` is high and `chip_addr` carries bits 7:0. In beats 2 and 3 both strobes are low and `chip_addr` is zero.
- R7: With hold low, a pending I/O request is granted ahead of a pending CPU request.
- R8: With hold high, the I/O request is never granted. A CPU request is served instead, and an I/O request alone starts no cycle.
- R9: Requests are sampled only at a cycle boundary. A request raised in the middle of a cycle does not change the grant. If it is still present at beat 3, the next cycle starts on the following clock at beat 0.
- R10: `store` is high during a cycle exactly when the granted request was a store.
- R11: Between cycles both grants, both strobes and `word_valid` are low, and `bank` and `chip_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU beat clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU memory request |
| cpu_store | input | 1 | CPU request is a store (1) or a fetch (0) |
| cpu_lsz | input | 2 | CPU size code: words = 2^code, code 3 treated as 2 |
| cpu_rev | input | 1 | CPU word order: 1 walks the group downward |
| cpu_addr | input | 20 | CPU word address |
| io_req | input | 1 | I/O memory request |
| io_store | input | 1 | I/O request is a store |
| io_lsz | input | 2 | I/O size code |
| io_rev | input | 1 | I/O word order |
| io_addr | input | 20 | I/O word address |
| hold | input | 1 | CPU hold bit, locks out I/O grants |
| cpu_gnt | output | 1 | Current cycle belongs to the CPU |
| io_gnt | output | 1 | Current cycle belongs to I/O |
| beat | output | 2 | Beat number within the cycle |
| store | output | 1 | Current cycle is a store |
| bank | output | 4 | Bank select |
| chip_addr | output | 8 | Multiplexed row/column chip address |
| row_strobe | output | 1 | `chip_addr` carries the row byte |
| col_strobe | output | 1 | `chip_addr` carries the column byte |
| word_valid | output | 1 | A word moves in this beat |
| word_addr | output | 20 | Word address of the word moved in this beat |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 4-bit bank field, 8-bit chip phases and four beats per cycle. With these values all three transfer sizes, both orders, the unused size code 3 and every bank come within reach of short runs. Seeded random requests, with random hold and overlapping CPU/I/O demand, exercise arbitration and alignment at arbitrary addresses. Directed cases add back-to-back I/O cycles, a CPU request raised in the middle of a cycle, and an I/O request that is blocked by hold with no CPU request behind it.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [0:0] {OWN_CPU = 1'b0, OWN_IO = 1'b1} owner_t;
endpackage

// File: rtl/mcs_arbiter.sv
module mcs_arbiter (
  input  logic boundary,
  input  logic cpu_req,
  input  logic io_req,
  input  logic hold,
  output logic start,
  output logic pick_io
);
  logic io_ok;

  // I/O is eligible only while the hold bit is clear
  assign io_ok   = io_req && !hold;
  assign pick_io = io_ok;
  assign start   = boundary && (io_ok || cpu_req);
endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned BEATS = 4,
  parameter int unsigned LSZ_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     pick_io,
  input  logic                     cpu_store,
  input  logic [LSZ_W-1:0]         cpu_lsz,
  input  logic                     cpu_rev,
  input  logic [AW-1:0]            cpu_addr,
  input  logic                     io_store,
  input  logic [LSZ_W-1:0]         io_lsz,
  input  logic                     io_rev,
  input  logic [AW-1:0]            io_addr,
  output logic                     boundary,
  output logic                     active,
  output logic [$clog2(BEATS)-1:0] beat,
  output owner_t                   owner,
  output logic                     store,
  output logic [LSZ_W-1:0]         lsz,
  output logic                     rev,
  output logic [AW-1:0]            base
);
  localparam int unsigned BW   = $clog2(BEATS);
  localparam int unsigned MAXL = BW;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic [LSZ_W-1:0] sel_lsz, clamp_lsz;
  logic [AW-1:0]    sel_addr;
  logic             sel_store, sel_rev;

  assign boundary = !active || (beat == LAST);

  always_comb begin
    sel_lsz   = pick_io ? io_lsz   : cpu_lsz;
    sel_addr  = pick_io ? io_addr  : cpu_addr;
    sel_store = pick_io ? io_store : cpu_store;
    sel_rev   = pick_io ? io_rev   : cpu_rev;
    clamp_lsz = (sel_lsz > LSZ_W'(MAXL)) ? LSZ_W'(MAXL) : sel_lsz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
      owner  <= OWN_CPU;
      store  <= 1'b0;
      lsz    <= '0;
      rev    <= 1'b0;
      base   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
      owner  <= pick_io ? OWN_IO : OWN_CPU;
      store  <= sel_store;
      lsz    <= clamp_lsz;
      rev    <= sel_rev;
      base   <= sel_addr & ({AW{1'b1}} << clamp_lsz);
    end else if (active) begin
      if (beat == LAST) begin
        active <= 1'b0;
        beat   <= '0;
        store  <= 1'b0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R2
  beat_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (active && beat != LAST) |=> (active && beat == $past(beat) + 1'b1));

  // R2
  owner_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (active && beat != LAST) |=> $stable(owner));
endmodule

// File: rtl/mcs_addr_mux.sv
module mcs_addr_mux #(
  parameter int unsigned AW     = 20,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned CAW    = 8,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned LSZ_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     active,
  input  logic [$clog2(BEATS)-1:0] beat,
  input  logic [LSZ_W-1:0]         lsz,
  input  logic                     rev,
  input  logic [AW-1:0]            base,
  output logic [BANK_W-1:0]        bank,
  output logic [CAW-1:0]           chip_addr,
  output logic                     row_strobe,
  output logic                     col_strobe,
  output logic                     word_valid,
  output logic [AW-1:0]            word_addr
);
  localparam int unsigned BW = $clog2(BEATS);
  localparam int unsigned CW = BW + 1;
  localparam int unsigned RB = AW - BANK_W;

  logic [CW-1:0] cnt, beat_x, off;

  always_comb begin
    cnt        = CW'(1) << lsz;
    beat_x     = {1'b0, beat};
    off        = rev ? (cnt - CW'(1) - beat_x) : beat_x;
    word_valid = active && (beat_x < cnt);
    word_addr  = base | AW'(off);
    bank       = active ? base[AW-1 -: BANK_W] : '0;
    row_strobe = active && (beat == BW'(0));
    col_strobe = active && (beat == BW'(1));
    if (row_strobe)      chip_addr = base[RB-1 -: CAW];
    else if (col_strobe) chip_addr = base[CAW-1:0];
    else                 chip_addr = '0;
  end

  // R4 R5
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && beat != BW'(0)) |->
      (word_addr == (rev ? $past(word_addr) - 1'b1 : $past(word_addr) + 1'b1)));
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
  import mcs_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned CAW    = 8,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned LSZ_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cpu_req,
  input  logic                     cpu_store,
  input  logic [LSZ_W-1:0]         cpu_lsz,
  input  logic                     cpu_rev,
  input  logic [AW-1:0]            cpu_addr,
  input  logic                     io_req,
  input  logic                     io_store,
  input  logic [LSZ_W-1:0]         io_lsz,
  input  logic                     io_rev,
  input  logic [AW-1:0]            io_addr,
  input  logic                     hold,
  output logic                     cpu_gnt,
  output logic                     io_gnt,
  output logic [$clog2(BEATS)-1:0] beat,
  output logic                     store,
  output logic [BANK_W-1:0]        bank,
  output logic [CAW-1:0]           chip_addr,
  output logic                     row_strobe,
  output logic                     col_strobe,
  output logic                     word_valid,
  output logic [AW-1:0]            word_addr
);
  logic             boundary, start, pick_io, active, rev;
  logic [LSZ_W-1:0] lsz;
  logic [AW-1:0]    base;
  owner_t           owner;

  mcs_arbiter u_arb (
    .boundary (boundary),
    .cpu_req  (cpu_req),
    .io_req   (io_req),
    .hold     (hold),
    .start    (start),
    .pick_io  (pick_io)
  );

  mcs_sequencer #(.AW(AW), .BEATS(BEATS), .LSZ_W(LSZ_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pick_io   (pick_io),
    .cpu_store (cpu_store),
    .cpu_lsz   (cpu_lsz),
    .cpu_rev   (cpu_rev),
    .cpu_addr  (cpu_addr),
    .io_store  (io_store),
    .io_lsz    (io_lsz),
    .io_rev    (io_rev),
    .io_addr   (io_addr),
    .boundary  (boundary),
    .active    (active),
    .beat      (beat),
    .owner     (owner),
    .store     (store),
    .lsz       (lsz),
    .rev       (rev),
    .base      (base)
  );

  mcs_addr_mux #(.AW(AW), .BANK_W(BANK_W), .CAW(CAW), .BEATS(BEATS), .LSZ_W(LSZ_W)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .beat       (beat),
    .lsz        (lsz),
    .rev        (rev),
    .base       (base),
    .bank       (bank),
    .chip_addr  (chip_addr),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .word_valid (word_valid),
    .word_addr  (word_addr)
  );

  assign cpu_gnt = active && (owner == OWN_CPU);
  assign io_gnt  = active && (owner == OWN_IO);

  // R8
  hold_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && hold) |=> !io_gnt);

  // R7
  io_first_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && io_req && !hold) |=> io_gnt);

  // R6
  col_after_row_chk: assert property (@(posedge clk) disable iff (rst)
    col_strobe |-> $past(row_strobe));
endmodule

// File: tb/tb_mem_cycle_seq.sv
module tb_mem_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_store = 0, cpu_rev = 0;
  logic [1:0]  cpu_lsz = 0;
  logic [19:0] cpu_addr = 0;
  logic        io_req = 0, io_store = 0, io_rev = 0;
  logic [1:0]  io_lsz = 0;
  logic [19:0] io_addr = 0;
  logic        hold = 0;
  logic        cpu_gnt, io_gnt, store, row_strobe, col_strobe, word_valid;
  logic [1:0]  beat;
  logic [3:0]  bank;
  logic [7:0]  chip_addr;
  logic [19:0] word_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_cycle_seq dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_store(cpu_store), .cpu_lsz(cpu_lsz), .cpu_rev(cpu_rev), .cpu_addr(cpu_addr),
    .io_req(io_req), .io_store(io_store), .io_lsz(io_lsz), .io_rev(io_rev), .io_addr(io_addr),
    .hold(hold), .cpu_gnt(cpu_gnt), .io_gnt(io_gnt), .beat(beat), .store(store), .bank(bank),
    .chip_addr(chip_addr), .row_strobe(row_strobe), .col_strobe(col_strobe),
    .word_valid(word_valid), .word_addr(word_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned eff_lsz(input logic [1:0] l);
    return (l == 2'd3) ? 2 : int'(l);
  endfunction

  function automatic logic [19:0] exp_word(input logic [19:0] a, input logic [1:0] l,
                                           input logic r, input int b);
    int unsigned n = 1 << eff_lsz(l);
    logic [19:0] base = a & ~20'(n - 1);
    return r ? base + 20'(n - 1 - b) : base + 20'(b);
  endfunction

  task automatic chk_idle(input string tag);
    chk({tag, " R11 grants"}, {30'd0, cpu_gnt, io_gnt}, 0);
    chk({tag, " R11 strobes"}, {29'd0, row_strobe, col_strobe, word_valid}, 0);
    chk({tag, " R11 bank/chip"}, {20'd0, bank, chip_addr}, 0);
  endtask

  // Called right after the edge that starts the cycle; samples at each negedge.
  task automatic chk_cycle(input bit is_io, input logic st, input logic [1:0] l,
                           input logic r, input logic [19:0] a);
    int unsigned n = 1 << eff_lsz(l);
    logic [19:0] base = a & ~20'(n - 1);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      chk("R2 beat", 32'(beat), 32'(b));
      chk(is_io ? "R7 io_gnt" : "R8 cpu_gnt", {30'd0, cpu_gnt, io_gnt}, is_io ? 1 : 2);
      chk("R10 store", 32'(store), 32'(st));
      chk("R3 word_valid", 32'(word_valid), 32'(b < int'(n)));
      if (b < int'(n))
        chk(r ? "R5 word_addr" : "R4 word_addr", 32'(word_addr), 32'(exp_word(a, l, r, b)));
      chk("R6 bank", 32'(bank), 32'(base[19:16]));
      chk("R6 strobes", {30'd0, row_strobe, col_strobe}, b == 0 ? 2 : (b == 1 ? 1 : 0));
      chk("R6 chip_addr", 32'(chip_addr), b == 0 ? 32'(base[15:8]) : (b == 1 ? 32'(base[7:0]) : 0));
    end
  endtask

  task automatic set_cpu(input logic st, input logic [1:0] l, input logic r, input logic [19:0] a);
    cpu_store = st; cpu_lsz = l; cpu_rev = r; cpu_addr = a;
  endtask

  task automatic set_io(input logic st, input logic [1:0] l, input logic r, input logic [19:0] a);
    io_store = st; io_lsz = l; io_rev = r; io_addr = a;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 beat in reset", 32'(beat), 0);
    chk_idle("R1 in reset");
    rst = 0;
    @(negedge clk);
    chk("R1 beat", 32'(beat), 0);
    chk("R1 store", 32'(store), 0);
    chk_idle("R1 after reset");

    // Directed: each size code, both orders, CPU alone
    for (int l = 0; l < 4; l++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        set_cpu(1'(l), 2'(l), 1'(r), 20'hA5C37);
        cpu_req = 1;
        @(posedge clk); #1 cpu_req = 0;
        chk_cycle(0, 1'(l), 2'(l), 1'(r), 20'hA5C37);
      end
    end

    // R7: both request, hold low -> I/O first, then CPU
    @(negedge clk);
    set_cpu(0, 2, 0, 20'h12345); set_io(1, 1, 1, 20'hFEDCB);
    cpu_req = 1; io_req = 1; hold = 0;
    @(posedge clk); #1 io_req = 0;
    chk_cycle(1, 1, 1, 1, 20'hFEDCB);
    @(posedge clk); #1 cpu_req = 0;
    chk_cycle(0, 0, 2, 0, 20'h12345);

    // R8: hold set -> CPU served despite I/O request
    @(negedge clk);
    set_cpu(1, 0, 0, 20'h0F0F0); set_io(0, 2, 0, 20'h33333);
    cpu_req = 1; io_req = 1; hold = 1;
    @(posedge clk); #1 cpu_req = 0;
    chk_cycle(0, 1, 0, 0, 20'h0F0F0);
    // R8: I/O alone under hold starts nothing
    @(negedge clk);
    chk_idle("R8 io blocked");
    @(negedge clk);
    chk_idle("R8 io blocked later");
    io_req = 0; hold = 0;

    // R9: back-to-back I/O, CPU raised mid-cycle waits for boundary
    @(negedge clk);
    set_io(0, 2, 1, 20'h80007); io_req = 1;
    @(posedge clk);
    chk_cycle(1, 0, 2, 1, 20'h80007);   // R9 io kept for second cycle
    // io_req still high at beat 3 edge: next cycle starts with no gap
    @(negedge clk);
    chk("R9 back-to-back beat", 32'(beat), 0);
    chk("R9 back-to-back io_gnt", 32'(io_gnt), 1);
    io_req = 0;
    set_cpu(0, 1, 0, 20'h44442); cpu_req = 1;   // raised in beat 0
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk("R9 grant held mid-cycle", {30'd0, cpu_gnt, io_gnt}, 1);
    end
    @(posedge clk); #1 cpu_req = 0;
    // this negedge-less entry: chk_cycle samples the beats of the CPU cycle
    chk_cycle(0, 0, 1, 0, 20'h44442);
    @(negedge clk);
    chk_idle("R11 after cycles");

    // Random traffic
    for (int i = 0; i < 200; i++) begin
      logic cr, ir, h, cs, is, crv, irv;
      logic [1:0] cl, il;
      logic [19:0] ca, ia;
      cr = 1'($urandom); ir = 1'($urandom); h = 1'($urandom);
      cs = 1'($urandom); is = 1'($urandom); crv = 1'($urandom); irv = 1'($urandom);
      cl = 2'($urandom); il = 2'($urandom); ca = 20'($urandom); ia = 20'($urandom);
      @(negedge clk);
      set_cpu(cs, cl, crv, ca); set_io(is, il, irv, ia);
      cpu_req = cr; io_req = ir; hold = h;
      @(posedge clk); #1 cpu_req = 0; io_req = 0;
      if (ir && !h)  chk_cycle(1, is, il, irv, ia);
      else if (cr)   chk_cycle(0, cs, cl, crv, ca);
      else begin
        @(negedge clk);
        chk_idle("R8 no eligible request");
      end
      hold = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule